// File: doc/BRIEF.md
# Four-Stage In-Order Pipeline with Branch Flush

This block is a small in-order processor pipeline with four one-cycle stages: instruction fetch, decode with address computation, operand fetch, and execute. It runs a six-operation instruction set from an instruction store. The environment fills that store through a load port while reset is held. An eight-entry register file and a small data memory hold the program's state.

Branches and jumps are resolved only in the execute stage. When one is taken, the three younger instructions in flight are turned into bubbles, and fetch restarts at the target in the next cycle. Each retirement raises a strobe that carries the instruction's address and any register result. A cycle counter allows the stage timing and the cost of a flush to be checked from outside.

No forwarding or interlock is present. A value written by one instruction is visible only to instructions at least two places later in program order, and the programs must keep to that spacing.

Top module: `branch_flush_pipe`

## Requirements
- R1: While reset is held and in the first cycle after it, `retire_valid` and `halted` are 0 and `cycle_count` is 1; the registers and data memory are cleared, and fetch starts at address 0.
- R2: With no taken branch, the instruction at position i (counting from 0) after reset retires while `cycle_count` equals i+4, so n instructions need n+3 cycles. `cycle_count` grows by one per cycle until a halt retires.
- R3: An instruction word has op in bits 15:13, field A in bits 12:10, field B in bits 9:7 and immediate in bits 6:0. Op 0 loads the zero-extended immediate into register A, and the retire strobe shows `retire_wen`=1, `retire_rd`=A and the value.
- R4: Op 1 writes register B plus data memory word (immediate mod data depth) into register A and reports the sum on retirement.
- R5: Op 2 stores register A into data memory word (immediate mod data depth); it retires with `retire_wen`=0.
- R6: Op 3 branches to the immediate address when register A is non-zero; when register A is zero it flows on with no lost cycle.
- R7: Op 4 always jumps to the immediate address, and it is resolved in execute like a conditional branch.
- R8: After a taken branch or jump, the next three fetched instructions never retire and never write a register or memory; the target retires exactly four cycles after the branch.
- R9: Op 7 retires, then `halted` rises in the next cycle; after that, nothing retires and `cycle_count` stays at the halt's retire cycle.
- R10: A register or memory value written by one instruction is read correctly by an instruction two positions later.
- R11: Ops 5 and 6 retire without changing any register or memory, with `retire_wen`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Write strobe for the instruction store |
| load_addr | input | IAW | Instruction store write address |
| load_instr | input | 16 | Instruction word to write |
| retire_valid | output | 1 | An instruction retires this cycle |
| retire_pc | output | IAW | Address of the retiring instruction |
| retire_wen | output | 1 | The retiring instruction writes a register |
| retire_rd | output | 3 | Destination register of the retiring instruction |
| retire_data | output | DW | Value written to the destination |
| halted | output | 1 | A halt has retired; the pipeline is stopped |
| cycle_count | output | CW | Cycle number since reset, frozen at halt |

## Verification
The properties assume that the instruction store is loaded only while reset is held. They also assume that every program ends in a halt, so that the freeze and stop checks have something to observe. The stimulus writes each program during reset and releases reset only once loading is complete. It separates every producer from its consumer by at least two instructions, and it places real instructions, including a store and a jump, in the slots behind each taken branch. A flush that fails to discard those slots therefore shows up in later results.

// File: rtl/branch_flush_pipe.sv
module branch_flush_pipe #(
  parameter int DW  = 16,
  parameter int IAW = 6,
  parameter int DAW = 4,
  parameter int CW  = 16
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_en,
  input  logic [IAW-1:0] load_addr,
  input  logic [15:0]    load_instr,
  output logic           retire_valid,
  output logic [IAW-1:0] retire_pc,
  output logic           retire_wen,
  output logic [2:0]     retire_rd,
  output logic [DW-1:0]  retire_data,
  output logic           halted,
  output logic [CW-1:0]  cycle_count
);
  localparam int IDEPTH = 1 << IAW;
  localparam int DDEPTH = 1 << DAW;
  localparam int IMMW   = 7;
  localparam logic [2:0] OP_LI = 3'd0, OP_ADD = 3'd1, OP_ST = 3'd2,
                         OP_BNZ = 3'd3, OP_JMP = 3'd4, OP_HALT = 3'd7;

  logic [15:0]   imem [IDEPTH];
  logic [DW-1:0] rf   [8];
  logic [DW-1:0] dmem [DDEPTH];
  logic [IAW-1:0] pc;

  logic           d_v;
  logic [IAW-1:0] d_pc;
  logic [15:0]    d_ir;

  logic           o_v;
  logic [IAW-1:0] o_pc, o_tgt;
  logic [2:0]     o_op, o_a, o_b;
  logic [DAW-1:0] o_da;
  logic [DW-1:0]  o_imm;

  logic           x_v, x_nz;
  logic [IAW-1:0] x_pc, x_tgt;
  logic [2:0]     x_op, x_a;
  logic [DAW-1:0] x_da;
  logic [DW-1:0]  x_res, x_sd;

  logic taken, halt_ret, kill, rf_we, dm_we;

  assign taken    = x_v && (x_op == OP_JMP || (x_op == OP_BNZ && x_nz));
  assign halt_ret = x_v && x_op == OP_HALT;
  assign kill     = taken || halt_ret;
  assign rf_we    = x_v && (x_op == OP_LI || x_op == OP_ADD);
  assign dm_we    = x_v && x_op == OP_ST;

  assign retire_valid = x_v;
  assign retire_pc    = x_pc;
  assign retire_wen   = rf_we;
  assign retire_rd    = x_a;
  assign retire_data  = x_res;

  always_ff @(posedge clk)
    if (load_en) imem[load_addr] <= load_instr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc          <= '0;
      d_v         <= 1'b0;
      o_v         <= 1'b0;
      x_v         <= 1'b0;
      halted      <= 1'b0;
      cycle_count <= {{(CW-1){1'b0}}, 1'b1};
    end else begin
      if (!halted) pc <= taken ? x_tgt : pc + 1'b1;
      d_v <= !halted && !kill;
      o_v <= d_v && !kill;
      x_v <= o_v && !kill;
      if (halt_ret) halted <= 1'b1;
      if (!halted && !halt_ret) cycle_count <= cycle_count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    d_pc  <= pc;
    d_ir  <= imem[pc];

    o_pc  <= d_pc;
    o_op  <= d_ir[15:13];
    o_a   <= d_ir[12:10];
    o_b   <= d_ir[9:7];
    o_tgt <= d_ir[IAW-1:0];
    o_da  <= d_ir[DAW-1:0];
    o_imm <= {{(DW-IMMW){1'b0}}, d_ir[IMMW-1:0]};

    x_pc  <= o_pc;
    x_op  <= o_op;
    x_a   <= o_a;
    x_tgt <= o_tgt;
    x_da  <= o_da;
    x_res <= (o_op == OP_LI) ? o_imm : rf[o_b] + dmem[o_da];
    x_sd  <= rf[o_a];
    x_nz  <= rf[o_a] != '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) rf[i] <= '0;
    end else if (rf_we) begin
      rf[x_a] <= x_res;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DDEPTH; i++) dmem[i] <= '0;
    end else if (dm_we) begin
      dmem[x_da] <= x_sd;
    end
  end
endmodule

module branch_flush_pipe_chk #(
  parameter int CW = 16
)(
  input logic          clk,
  input logic          rst_n,
  input logic          retire_valid,
  input logic          halted,
  input logic [CW-1:0] cycle_count,
  input logic          taken,
  input logic          halt_ret,
  input logic          rf_we,
  input logic          dm_we,
  input logic          d_v
);
  // R8
  taken_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> !retire_valid && !rf_we && !dm_we);

  // R9
  halt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_ret |=> halted);

  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(cycle_count) && !retire_valid);

  // R9
  halt_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !d_v);

  // R2
  cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && !halt_ret) |=> cycle_count == $past(cycle_count) + 1'b1);
endmodule

bind branch_flush_pipe branch_flush_pipe_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .retire_valid(retire_valid), .halted(halted),
  .cycle_count(cycle_count), .taken(taken), .halt_ret(halt_ret),
  .rf_we(rf_we), .dm_we(dm_we), .d_v(d_v)
);

// File: tb/branch_flush_pipe_bench.sv
module branch_flush_pipe_bench;
  localparam int DW = 16, IAW = 6, DAW = 4, CW = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           load_en = 1'b0;
  logic [IAW-1:0] load_addr = '0;
  logic [15:0]    load_instr = '0;
  logic           retire_valid, retire_wen, halted;
  logic [IAW-1:0] retire_pc;
  logic [2:0]     retire_rd;
  logic [DW-1:0]  retire_data;
  logic [CW-1:0]  cycle_count;

  branch_flush_pipe #(.DW(DW), .IAW(IAW), .DAW(DAW), .CW(CW)) u_branch_flush_pipe (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_instr(load_instr), .retire_valid(retire_valid), .retire_pc(retire_pc),
    .retire_wen(retire_wen), .retire_rd(retire_rd), .retire_data(retire_data),
    .halted(halted), .cycle_count(cycle_count)
  );

  always #2 clk = ~clk;

  typedef struct {
    int    pc;
    int    cyc;
    bit    wen;
    int    rd;
    int    data;
    string req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic logic [15:0] enc(int op, int a, int b, int imm);
    return {op[2:0], a[2:0], b[2:0], imm[6:0]};
  endfunction

  task automatic put(int addr, logic [15:0] w);
    @(negedge clk);
    load_en    = 1'b1;
    load_addr  = addr[IAW-1:0];
    load_instr = w;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic expect_ret(int pc, int cyc, bit wen, int rd, int data, string req);
    exp_t e;
    e.pc = pc; e.cyc = cyc; e.wen = wen; e.rd = rd; e.data = data; e.req = req;
    q.push_back(e);
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && retire_valid && !done) begin
      if (q.size() == 0) begin
        check(1'b0, "R8", "unexpected retire pc", int'(retire_pc), -1);
      end else begin
        exp_t e;
        bit ok;
        e = q.pop_front();
        ok = int'(retire_pc) == e.pc && int'(cycle_count) == e.cyc && retire_wen == e.wen;
        if (e.wen) ok = ok && int'(retire_rd) == e.rd && int'(retire_data) == e.data;
        checks++;
        if (!ok) begin
          errors++;
          $display("FAIL %s retire: actual pc=%0d cyc=%0d wen=%0d rd=%0d data=%0d expected pc=%0d cyc=%0d wen=%0d rd=%0d data=%0d",
                   e.req, retire_pc, cycle_count, retire_wen, retire_rd, retire_data,
                   e.pc, e.cyc, e.wen, e.rd, e.data);
        end
      end
    end
  end

  task automatic run(int final_cyc, string req);
    int n;
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    while (!halted && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(halted == 1'b1, req, "halted reached", int'(halted), 1);
    repeat (8) @(negedge clk);
    // R9: counter frozen at the halt retire cycle, nothing left over
    check(int'(cycle_count) == final_cyc, "R9", "frozen cycle_count", int'(cycle_count), final_cyc);
    check(q.size() == 0, req, "pending retires", q.size(), 0);
    q.delete();
    rst_n = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(retire_valid == 1'b0, "R1", "retire_valid in reset", int'(retire_valid), 0);
    check(halted == 1'b0, "R1", "halted in reset", int'(halted), 0);
    check(int'(cycle_count) == 1, "R1", "cycle_count in reset", int'(cycle_count), 1);

    // Program A: straight line (R2 R3 R4 R5 R10 R11)
    put(0, enc(0, 1, 0, 5));
    put(1, enc(0, 2, 0, 7));
    put(2, enc(2, 1, 0, 3));
    put(3, enc(5, 3, 3, 3));
    put(4, enc(1, 4, 2, 3));
    put(5, enc(7, 0, 0, 0));
    expect_ret(0, 4, 1, 1, 5, "R3");
    expect_ret(1, 5, 1, 2, 7, "R2");
    expect_ret(2, 6, 0, 0, 0, "R5");
    expect_ret(3, 7, 0, 0, 0, "R11");
    expect_ret(4, 8, 1, 4, 12, "R4_R10");
    expect_ret(5, 9, 0, 0, 0, "R9");
    run(9, "R2");

    // Program B: taken branch, three younger slots hold LI, ST and JMP (R6 R8)
    put(0, enc(0, 1, 0, 1));
    put(1, enc(0, 2, 0, 2));
    put(2, enc(3, 1, 0, 20));
    put(3, enc(0, 5, 0, 9));
    put(4, enc(2, 2, 0, 5));
    put(5, enc(4, 0, 0, 50));
    put(20, enc(1, 7, 2, 5));
    put(21, enc(1, 3, 5, 5));
    put(22, enc(7, 0, 0, 0));
    expect_ret(0, 4, 1, 1, 1, "R3");
    expect_ret(1, 5, 1, 2, 2, "R3");
    expect_ret(2, 6, 0, 0, 0, "R6");
    expect_ret(20, 10, 1, 7, 2, "R8");
    expect_ret(21, 11, 1, 3, 0, "R8");
    expect_ret(22, 12, 0, 0, 0, "R9");
    run(12, "R8");

    // Program C: branch not taken, then unconditional jump (R6 R7)
    put(0, enc(0, 1, 0, 0));
    put(1, enc(0, 2, 0, 4));
    put(2, enc(3, 1, 0, 30));
    put(3, enc(0, 3, 0, 6));
    put(4, enc(4, 0, 0, 40));
    put(5, enc(0, 3, 0, 1));
    put(40, enc(1, 5, 3, 0));
    put(41, enc(7, 0, 0, 0));
    expect_ret(0, 4, 1, 1, 0, "R3");
    expect_ret(1, 5, 1, 2, 4, "R3");
    expect_ret(2, 6, 0, 0, 0, "R6");
    expect_ret(3, 7, 1, 3, 6, "R6");
    expect_ret(4, 8, 0, 0, 0, "R7");
    expect_ret(40, 12, 1, 5, 6, "R7");
    expect_ret(41, 13, 0, 0, 0, "R9");
    run(13, "R7");

    // Program D: jump landing on another jump, widest immediate (R7 R8 R3)
    put(0, enc(0, 1, 0, 3));
    put(1, enc(4, 0, 0, 8));
    put(8, enc(4, 0, 0, 12));
    put(12, enc(0, 2, 0, 127));
    put(13, enc(7, 0, 0, 0));
    expect_ret(0, 4, 1, 1, 3, "R3");
    expect_ret(1, 5, 0, 0, 0, "R7");
    expect_ret(8, 9, 0, 0, 0, "R8");
    expect_ret(12, 13, 1, 2, 127, "R3");
    expect_ret(13, 14, 0, 0, 0, "R9");
    run(14, "R8");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1'b1;
    checks++;
    errors++;
    $display("FAIL R9 watchdog: actual %0d cycles expected fewer", 20000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule